// File: doc/BRIEF.md
# Serial Real-Time Word Monitor

This block watches four words of a sample memory on every computation pass and sends them out serially on a single test pin. Four address registers choose the words. When a pass-start strobe arrives while the monitor is enabled, the block reads the four words through a one-cycle-latency synchronous read port. It then shifts them out back to back as fixed 35-bit frames. Each frame has a leading flag bit so that an external capture tool can align to it.

The serial data line stays low whenever no frame is being shifted. A gated copy of the shift clock is driven out only when the clock-output enable is set, so a logic analyser can sample the data line against it. Selecting which pass starts a burst, and routing the pin onto a shared test multiplexer, belong to the surrounding logic.

Top module: `word_monitor`

## Requirements
- R1: While reset is asserted (synchronous, active low) and after its release with no strobe, `ser_data_o` and `mem_rd_en_o` are 0.
- R2: Whenever no frame is being shifted, `ser_data_o` is 0.
- R3: The pass-start strobe starts a burst only if it is sampled high at a rising edge while the block is idle and enabled. The flag bit of the first frame appears on `ser_data_o` in the third cycle after that edge.
- R4: Each frame lasts 35 clocks. It carries bit value 1 first, then the 32 data bits with bit 31 first and bit 0 last, then two 0 bits.
- R5: One burst carries four frames with no gap between them, in address-register order: slot 0 (bits [ADDR_W-1:0] of `sel_addr_i`) first, slot 3 last. The burst is 140 cycles long.
- R6: Each word is read with a single-cycle `mem_rd_en_o` pulse carrying that slot's address, and the read data is taken one cycle later. Slot 0 is read in the cycle right after the starting edge. Slot k+1 is read during bit 33 of frame k. A burst makes exactly four reads.
- R7: A pass-start strobe that arrives during a burst is ignored. The burst finishes unchanged, and no second burst follows.
- R8: Clearing `mon_en_i` forces `ser_data_o` low in the same cycle and returns the block to idle. Setting it again does not resume the burst without a new strobe.
- R9: A pass-start strobe is ignored while `mon_en_i` is 0: no reads are made and the line stays low.
- R10: `ser_clk_o` follows `clk` while `clk_out_en_i` is 1 and is held at 0 while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pass_start_i | input | 1 | One-cycle strobe marking the start of a computation pass |
| mon_en_i | input | 1 | Monitor enable |
| clk_out_en_i | input | 1 | Enables the clock copy on `ser_clk_o` |
| sel_addr_i | input | 4*ADDR_W | Four word addresses, slot k in bits [k*ADDR_W +: ADDR_W] |
| mem_rd_en_o | output | 1 | Read strobe to the sample memory |
| mem_rd_addr_o | output | ADDR_W | Read address |
| mem_rd_data_i | input | DATA_W | Read data, valid the cycle after the strobe |
| ser_data_o | output | 1 | Serial monitor data |
| ser_clk_o | output | 1 | Gated copy of the shift clock |

## Verification
Counted from the edge that samples the strobe, the first read pulse is due one cycle later. The first flag bit is due three cycles later. Bit b of the burst falls in cycle 3+b, so the line is low again from cycle 143. The later reads fall in cycles 3+35k+33. The bench drives inputs on falling edges and samples on the falling edge of each cycle. It compares every cycle of a burst against a stream built arithmetically from a model memory. Enable-drop checks sample one time step after the input changes, because the line must fall within that same cycle.

// File: rtl/wmon_pkg.sv
// Shared types for the serial word monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package wmon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_CAPT  = 2'd2,
        ST_SEND  = 2'd3
    } wmon_state_e;
endpackage

// File: rtl/wmon_ctrl.sv
// Burst sequencer: waits for a pass start, fetches each word one cycle
// ahead of its frame, and counts frame bits and word slots.
// Assumes: the read port returns data exactly one cycle after the strobe.
module wmon_ctrl
    import wmon_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int FRAME_LEN = 35,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             en_i,
    output logic             rd_en_o,
    output logic [IDX_W-1:0] rd_idx_o,
    output logic             load_o,
    output logic             shift_o,
    output logic             active_o
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] FETCH_BIT = CNT_W'(FRAME_LEN - 2);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_WORDS - 1);

    wmon_state_e      state;
    logic [CNT_W-1:0] bit_cnt;
    logic [IDX_W-1:0] idx;
    logic             more_words;

    assign more_words = (idx != LAST_IDX);

    // Purpose: advance the burst state, bit counter and word slot.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            idx     <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_i) begin
                    state <= ST_FETCH;
                    idx   <= '0;
                end
                ST_FETCH: state <= ST_CAPT;
                ST_CAPT: begin
                    state   <= ST_SEND;
                    bit_cnt <= '0;
                end
                ST_SEND: begin
                    if (bit_cnt == LAST_BIT) begin
                        bit_cnt <= '0;
                        if (more_words) idx   <= idx + 1'b1;
                        else            state <= ST_IDLE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: derive read strobe, slot select and shifter commands.
    always_comb begin
        rd_en_o  = en_i && ((state == ST_FETCH) ||
                   (state == ST_SEND && bit_cnt == FETCH_BIT && more_words));
        rd_idx_o = (state == ST_SEND) ? idx + 1'b1 : idx;
        load_o   = en_i && ((state == ST_CAPT) ||
                   (state == ST_SEND && bit_cnt == LAST_BIT && more_words));
        shift_o  = (state == ST_SEND);
        active_o = (state == ST_SEND);
    end
endmodule

// File: rtl/wmon_addr_sel.sv
// Address selector: picks the address register of the slot being fetched.
// Assumes: slot index is always below NUM_WORDS.
module wmon_addr_sel #(
    parameter int NUM_WORDS = 4,
    parameter int ADDR_W    = 8,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic [NUM_WORDS*ADDR_W-1:0] addr_tab_i,
    input  logic [IDX_W-1:0]            idx_i,
    output logic [ADDR_W-1:0]           addr_o
);
    logic [NUM_WORDS-1:0][ADDR_W-1:0] term;

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
        // Purpose: pass slot g's address only when it is selected.
        assign term[g] = (idx_i == IDX_W'(g)) ? addr_tab_i[g*ADDR_W +: ADDR_W] : '0;
    end

    // Purpose: OR the one-hot-selected terms together.
    always_comb begin
        addr_o = '0;
        for (int i = 0; i < NUM_WORDS; i++) addr_o = addr_o | term[i];
    end
endmodule

// File: rtl/wmon_shifter.sv
// Frame shifter: loads flag, data word and trailing zeros, then shifts
// them out MSB first, one bit per clock.
// Assumes: load and shift are never requested in a way that needs both.
module wmon_shifter #(
    parameter int DATA_W    = 32,
    parameter int TAIL_BITS = 2,
    localparam int FRAME_LEN = 1 + DATA_W + TAIL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o
);
    logic [FRAME_LEN-1:0] shreg;

    // Purpose: hold the frame being sent; load wins over shift.
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg <= '0;
        else if (load_i)  shreg <= {1'b1, data_i, {TAIL_BITS{1'b0}}};
        else if (shift_i) shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
    end

    assign bit_o = shreg[FRAME_LEN-1];
endmodule

// File: rtl/word_monitor.sv
// Serial word monitor top: on each pass start, reads four selected words
// and sends them as flagged frames on one data line, with a gated clock.
// Assumes: synchronous memory with one cycle read latency.
module word_monitor #(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 4,
    parameter int TAIL_BITS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        pass_start_i,
    input  logic                        mon_en_i,
    input  logic                        clk_out_en_i,
    input  logic [NUM_WORDS*ADDR_W-1:0] sel_addr_i,
    output logic                        mem_rd_en_o,
    output logic [ADDR_W-1:0]           mem_rd_addr_o,
    input  logic [DATA_W-1:0]           mem_rd_data_i,
    output logic                        ser_data_o,
    output logic                        ser_clk_o
);
    localparam int FRAME_LEN = 1 + DATA_W + TAIL_BITS;
    localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

    logic             load;
    logic             shift;
    logic             burst_active;
    logic             shreg_bit;
    logic [IDX_W-1:0] rd_idx;

    wmon_ctrl #(.NUM_WORDS(NUM_WORDS), .FRAME_LEN(FRAME_LEN)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (pass_start_i),
        .en_i     (mon_en_i),
        .rd_en_o  (mem_rd_en_o),
        .rd_idx_o (rd_idx),
        .load_o   (load),
        .shift_o  (shift),
        .active_o (burst_active)
    );

    wmon_addr_sel #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) sel_i (
        .addr_tab_i (sel_addr_i),
        .idx_i      (rd_idx),
        .addr_o     (mem_rd_addr_o)
    );

    wmon_shifter #(.DATA_W(DATA_W), .TAIL_BITS(TAIL_BITS)) shf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .shift_i (shift),
        .data_i  (mem_rd_data_i),
        .bit_o   (shreg_bit)
    );

    // Purpose: line low outside frames and the instant enable drops.
    assign ser_data_o = burst_active && mon_en_i && shreg_bit;

    // Purpose: clock copy for the pin, held low when not enabled.
    assign ser_clk_o = clk & clk_out_en_i;
endmodule

// File: rtl/word_monitor_chk.sv
// Assertion checker for the serial word monitor, bound to every instance.
// Assumes: reset is held low from time zero.
module word_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic mon_en_i,
    input logic mem_rd_en_o,
    input logic ser_data_o,
    input logic burst_active
);
    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_active |-> !ser_data_o);

    p_flag_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(burst_active) && mon_en_i) |-> ser_data_o);

    p_single_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);

    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |-> (!ser_data_o && !mem_rd_en_o));

    p_off_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |=> !burst_active);

    p_no_read_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en_i |=> !$rose(burst_active));
endmodule

bind word_monitor word_monitor_chk chk_i (.*);

// File: tb/word_monitor_tb_top.sv
// Bench: sweeps address sets over a computed memory image and compares
// every cycle of each burst against an arithmetically built stream.
module word_monitor_tb_top;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int NW = 4;
    localparam int BURST = 140;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          en = 1'b0;
    logic          ckoe = 1'b0;
    logic [NW*AW-1:0] sel = '0;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;
    logic          sdat;
    logic          sclk;

    int n_vec  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    word_monitor #(.ADDR_W(AW), .DATA_W(DW), .NUM_WORDS(NW), .TAIL_BITS(2)) dut_i (
        .clk (clk), .rst_n (rst_n), .pass_start_i (start), .mon_en_i (en),
        .clk_out_en_i (ckoe), .sel_addr_i (sel), .mem_rd_en_o (rd_en),
        .mem_rd_addr_o (rd_addr), .mem_rd_data_i (rd_data),
        .ser_data_o (sdat), .ser_clk_o (sclk)
    );

    function automatic logic [DW-1:0] memval(input logic [AW-1:0] a);
        if (a == '0) return '0;
        if (a == '1) return '1;
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A0F00F0;
    endfunction

    // Model memory: one-cycle read latency.
    always @(posedge clk) if (rd_en) rd_data <= memval(rd_addr);

    task automatic chk(input string req, input logic act, input logic exp, input int at);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: got %b expected %b", req, at, act, exp);
        end
    endtask

    task automatic chk_addr(input logic [AW-1:0] act, input logic [AW-1:0] exp, input int at);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R6 cycle %0d: address %0d expected %0d", at, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int b);
        int w = b / 35;
        int k = b % 35;
        logic [DW-1:0] word = memval(sel[w*AW +: AW]);
        if (k == 0) return 1'b1;
        if (k <= 32) return word[32-k];
        return 1'b0;
    endfunction

    // Full burst with optional stray strobe at cycle inj (R3..R7).
    task automatic burst(input int inj);
        @(negedge clk); start = 1'b1;
        for (int c = 1; c < BURST + 10; c++) begin
            logic ebit;
            logic erd;
            int   slot;
            @(negedge clk);
            ebit = (c >= 3 && c < 3 + BURST) ? exp_bit(c - 3) : 1'b0;
            slot = -1;
            if (c == 1) slot = 0;
            for (int w = 1; w < NW; w++) if (c == 3 + 35*(w-1) + 33) slot = w;
            erd = (slot >= 0);
            chk((c < 3 || c >= 3 + BURST) ? "R2" : "R4/R5", sdat, ebit, c);
            chk("R6", rd_en, erd, c);
            if (erd) chk_addr(rd_addr, sel[slot*AW +: AW], c);
            start = (c == inj);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", sdat, 1'b0, i);
            chk("R1", rd_en, 1'b0, i);
        end
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", sdat, 1'b0, i);
            chk("R1", rd_en, 1'b0, i);
        end

        // R9: strobe while disabled is ignored
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R9", sdat, 1'b0, i);
            chk("R9", rd_en, 1'b0, i);
        end

        // R3/R4/R5/R6: sweep of address sets
        en = 1'b1;
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < NW; k++)
                sel[k*AW +: AW] = AW'((s * 5 + k * 3 + (s & k)) % 16);
            burst(-1);
        end
        sel = {4'd15, 4'd0, 4'd15, 4'd0};
        burst(-1);
        sel = {4'd7, 4'd7, 4'd7, 4'd7};
        burst(-1);

        // R7: stray strobes inside a burst
        sel = {4'd1, 4'd2, 4'd3, 4'd4};
        burst(2);
        burst(60);
        burst(3 + BURST - 1);

        // R8: enable drops mid burst
        for (int cut = 5; cut < 140; cut += 37) begin
            sel = {4'd9, 4'd10, 4'd11, 4'd15};
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            for (int c = 2; c < cut; c++) @(negedge clk);
            en = 1'b0;
            #1 chk("R8", sdat, 1'b0, cut);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                chk("R8", sdat, 1'b0, i);
                chk("R8", rd_en, 1'b0, i);
            end
            en = 1'b1;
            for (int i = 0; i < 160; i++) begin
                @(negedge clk);
                chk("R8", sdat, 1'b0, i);
                chk("R8", rd_en, 1'b0, i);
            end
            burst(-1);
        end

        // R10: gated clock copy
        for (int m = 0; m < 2; m++) begin
            ckoe = (m == 1);
            for (int i = 0; i < 6; i++) begin
                @(posedge clk); #1 chk("R10", sclk, ckoe, i);
                @(negedge clk); #1 chk("R10", sclk, 1'b0, i);
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule